// File: doc/BRIEF.md
# SMT Fetch Thread Selector

This block sits in the front end of a simultaneous multithreading core and decides, every cycle, which hardware threads may send an instruction-cache request and how many instructions each of them may take. For each thread it keeps three saturating counters. The first counts instructions in flight between decode and the instruction queue. The second counts unresolved branches. The third counts outstanding data-cache misses. The counters are moved by single-cycle increment and decrement pulses from the pipeline stages that own those events. A fourth metric, the distance of each thread's oldest queued instruction from the queue head, comes in directly as an input.

A two-bit policy input chooses the metric used for ranking. A lower metric wins, except that a larger queue distance wins under the queue-position policy. Ties are broken by a rotating pointer. A two-bit mode input chooses how the fetch width is divided among threads. A thread is eligible only when it is active, is not waiting on an instruction-cache miss, and is not being flushed. The grant outputs are combinational from the counter state and the current inputs.

Top module: `fts_select`

## Requirements
- R1: After reset all counters are zero and the tie pointer is 0, so with every thread eligible and all metrics equal, slots are granted to threads in ascending order starting at thread 0.
- R2: The mode input sets the slot count and the per-slot budget. Code 0 gives 1 slot with the full fetch width (8). Code 1 gives 2 slots with half width (4). Code 2 gives 4 slots with a quarter width (2). Code 3 gives 2 slots with the full width (8). Valid slots are packed from slot 0 upward.
- R3: Policy code 0 ranks threads by the fewest in-flight decode-to-queue instructions.
- R4: Policy code 1 ranks threads by the fewest unresolved branches.
- R5: Policy code 2 ranks threads by the fewest outstanding data-cache misses.
- R6: Policy code 3 ranks threads by the largest queue distance first.
- R7: A thread that is inactive, stalled on an instruction-cache miss, or being flushed in the current cycle is never granted. A slot that is not filled carries valid 0, thread ID 0 and budget 0.
- R8: Among equal metrics, the winner is the thread reached first when counting upward (modulo 8) from the tie pointer. The pointer advances by one after each cycle that issues at least one grant, and holds otherwise.
- R9: Each counter saturates at 63 and at 0. An increment and a decrement in the same cycle leave the counter unchanged.
- R10: A flush pulse for a thread clears all three of its counters at that clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_policy | input | 2 | Ranking metric select (R3 to R6) |
| cfg_mode | input | 2 | Slot and budget partition (R2) |
| thr_active | input | 8 | Thread has a running context |
| thr_imiss | input | 8 | Thread is stalled on an instruction-cache miss |
| thr_flush | input | 8 | Thread is flushed this cycle |
| occ_inc | input | 8 | Instruction entered decode, one per thread |
| occ_dec | input | 8 | Instruction left the queue, one per thread |
| br_inc | input | 8 | Branch decoded, one per thread |
| br_dec | input | 8 | Branch resolved, one per thread |
| dmiss_inc | input | 8 | Data-cache miss started, one per thread |
| dmiss_dec | input | 8 | Data-cache miss filled, one per thread |
| qpos_dist | input | 48 | Per-thread queue distance, 6 bits per thread, thread t at bits [6t+5:6t] |
| grant_vld | output | 4 | Slot valid bits |
| grant_tid | output | 12 | Slot thread IDs, 3 bits per slot, slot s at bits [3s+2:3s] |
| grant_budget | output | 16 | Slot instruction budgets, 4 bits per slot |

## Verification
The bench builds the block with its default parameters: 8 threads, 6-bit counters and distances, and an 8-wide fetch. These values are small enough that a counter can be driven past both saturation limits in about seventy cycles, and large enough that the four-slot mode leaves threads that are ranked but not granted. The per-thread metrics are preset to distinct values so that each policy gives a different ordering. The tie pointer is held frozen by withdrawing all eligibility between checks, which lets the wrap of the rotation order be checked at known pointer values.

// File: rtl/fts_pkg.sv
`timescale 1ns/1ps
// Shared encodings for the fetch thread selector.
// Assumes: the policy and mode codes are driven by configuration and are stable.
package fts_pkg;
    typedef enum logic [1:0] {
        POL_OCC    = 2'd0,
        POL_BRANCH = 2'd1,
        POL_DMISS  = 2'd2,
        POL_QPOS   = 2'd3
    } fetch_policy_e;

    typedef enum logic [1:0] {
        MODE_ONE_FULL   = 2'd0,
        MODE_TWO_HALF   = 2'd1,
        MODE_FOUR_QUART = 2'd2,
        MODE_TWO_FULL   = 2'd3
    } fetch_mode_e;

    localparam int GRANT_SLOTS = 4;
endpackage

// File: rtl/fts_sat_counter.sv
`timescale 1ns/1ps
// Up/down counter that saturates at both ends, with a clear input that wins.
// Assumes: inc and dec are single-cycle event pulses; both high means a net change of zero.
module fts_sat_counter #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    input  logic         dec,
    output logic [W-1:0] cnt
);
    localparam logic [W-1:0] CMAX = '1;

    // Apply clear, then a single-direction step bounded by the limits.
    always_ff @(posedge clk) begin
        if (!rst_n)                             cnt <= '0;
        else if (clr)                           cnt <= '0;
        else if (inc && !dec && cnt != CMAX)    cnt <= cnt + 1'b1;
        else if (dec && !inc && cnt != '0)      cnt <= cnt - 1'b1;
    end

    a_r9_top_sticks: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && inc && !dec && cnt == CMAX) |=> (cnt == CMAX));
    a_r9_bottom_sticks: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && dec && !inc && cnt == '0) |=> (cnt == '0));
    a_r9_net_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && inc && dec) |=> $stable(cnt));
    a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt == '0));
endmodule

// File: rtl/fts_pick.sv
`timescale 1ns/1ps
// Ordered selection of up to SLOTS eligible threads by ascending key.
// Ties are broken by the distance counted upward from ptr.
// Assumes: N is a power of two, so the rotation distance wraps naturally.
module fts_pick #(
    parameter int N     = 8,
    parameter int KW    = 6,
    parameter int SLOTS = 4,
    localparam int IW = $clog2(N),
    localparam int SW = $clog2(SLOTS + 1)
) (
    input  logic [N-1:0][KW-1:0]    key,
    input  logic [N-1:0]            elig,
    input  logic [IW-1:0]           ptr,
    input  logic [SW-1:0]           nslots,
    output logic [SLOTS-1:0]        vld,
    output logic [SLOTS-1:0][IW-1:0] tid
);
    logic [N-1:0]       taken;
    logic               found;
    logic [IW-1:0]      bidx;
    logic [IW-1:0]      rot;
    logic [KW+IW-1:0]   bcost;
    logic [KW+IW-1:0]   cost;

    // Repeated minimum search; each winner is removed before the next slot.
    always_comb begin
        vld   = '0;
        tid   = '0;
        taken = '0;
        found = 1'b0;
        bidx  = '0;
        bcost = '1;
        rot   = '0;
        cost  = '0;
        for (int s = 0; s < SLOTS; s++) begin
            found = 1'b0;
            bidx  = '0;
            bcost = '1;
            for (int t = 0; t < N; t++) begin
                rot  = IW'(t) - ptr;
                cost = {key[t], rot};
                if (elig[t] && !taken[t] && (!found || cost < bcost)) begin
                    found = 1'b1;
                    bidx  = IW'(t);
                    bcost = cost;
                end
            end
            if (found && (s < int'(nslots))) begin
                vld[s]      = 1'b1;
                tid[s]      = bidx;
                taken[bidx] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/fts_select.sv
`timescale 1ns/1ps
// Fetch thread selector: per-thread event counters, policy key mux,
// eligibility mask, partition decode, and the rotating tie pointer.
// Assumes: N_THR is a power of two; event pulses are one cycle wide.
module fts_select #(
    parameter int N_THR   = 8,
    parameter int CNT_W   = 6,
    parameter int DIST_W  = 6,
    parameter int FETCH_W = 8,
    localparam int IW    = $clog2(N_THR),
    localparam int SLOTS = fts_pkg::GRANT_SLOTS,
    localparam int BW    = $clog2(FETCH_W + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [1:0]               cfg_policy,
    input  logic [1:0]               cfg_mode,
    input  logic [N_THR-1:0]         thr_active,
    input  logic [N_THR-1:0]         thr_imiss,
    input  logic [N_THR-1:0]         thr_flush,
    input  logic [N_THR-1:0]         occ_inc,
    input  logic [N_THR-1:0]         occ_dec,
    input  logic [N_THR-1:0]         br_inc,
    input  logic [N_THR-1:0]         br_dec,
    input  logic [N_THR-1:0]         dmiss_inc,
    input  logic [N_THR-1:0]         dmiss_dec,
    input  logic [N_THR*DIST_W-1:0]  qpos_dist,
    output logic [SLOTS-1:0]         grant_vld,
    output logic [SLOTS*IW-1:0]      grant_tid,
    output logic [SLOTS*BW-1:0]      grant_budget
);
    import fts_pkg::*;

    localparam int KW = (CNT_W > DIST_W) ? CNT_W : DIST_W;
    localparam int SW = $clog2(SLOTS + 1);

    logic [N_THR-1:0][CNT_W-1:0] occ_cnt, br_cnt, dm_cnt;
    logic [N_THR-1:0][KW-1:0]    key;
    logic [N_THR-1:0]            elig;
    logic [IW-1:0]               ptr;
    logic [SW-1:0]               nslots;
    logic [BW-1:0]               budget;
    logic [SLOTS-1:0]            pick_vld;
    logic [SLOTS-1:0][IW-1:0]    pick_tid;

    // Three saturating counters per thread, cleared by that thread's flush.
    for (genvar g = 0; g < N_THR; g++) begin : g_thr
        fts_sat_counter #(.W(CNT_W)) u_occ (
            .clk(clk), .rst_n(rst_n), .clr(thr_flush[g]),
            .inc(occ_inc[g]), .dec(occ_dec[g]), .cnt(occ_cnt[g]));
        fts_sat_counter #(.W(CNT_W)) u_br (
            .clk(clk), .rst_n(rst_n), .clr(thr_flush[g]),
            .inc(br_inc[g]), .dec(br_dec[g]), .cnt(br_cnt[g]));
        fts_sat_counter #(.W(CNT_W)) u_dm (
            .clk(clk), .rst_n(rst_n), .clr(thr_flush[g]),
            .inc(dmiss_inc[g]), .dec(dmiss_dec[g]), .cnt(dm_cnt[g]));
    end

    // Select each thread's ranking key; queue distance is inverted so farther wins.
    always_comb begin
        for (int t = 0; t < N_THR; t++) begin
            case (fetch_policy_e'(cfg_policy))
                POL_OCC:    key[t] = KW'(occ_cnt[t]);
                POL_BRANCH: key[t] = KW'(br_cnt[t]);
                POL_DMISS:  key[t] = KW'(dm_cnt[t]);
                default:    key[t] = KW'(~qpos_dist[t*DIST_W +: DIST_W]);
            endcase
        end
    end

    // Eligibility mask: running, not waiting on fetch, not being flushed.
    assign elig = thr_active & ~thr_imiss & ~thr_flush;

    // Decode the partition mode into a slot count and a per-slot budget.
    always_comb begin
        case (fetch_mode_e'(cfg_mode))
            MODE_ONE_FULL:   begin nslots = SW'(1); budget = BW'(FETCH_W);     end
            MODE_TWO_HALF:   begin nslots = SW'(2); budget = BW'(FETCH_W / 2); end
            MODE_FOUR_QUART: begin nslots = SW'(4); budget = BW'(FETCH_W / 4); end
            default:         begin nslots = SW'(2); budget = BW'(FETCH_W);     end
        endcase
    end

    fts_pick #(.N(N_THR), .KW(KW), .SLOTS(SLOTS)) u_pick (
        .key(key), .elig(elig), .ptr(ptr), .nslots(nslots),
        .vld(pick_vld), .tid(pick_tid));

    // Advance the tie pointer after every cycle that issues a grant.
    always_ff @(posedge clk) begin
        if (!rst_n)          ptr <= '0;
        else if (|pick_vld)  ptr <= ptr + 1'b1;
    end

    // Flatten the slot outputs; an empty slot reports zero budget.
    assign grant_vld = pick_vld;
    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        assign grant_tid[s*IW +: IW]    = pick_tid[s];
        assign grant_budget[s*BW +: BW] = pick_vld[s] ? budget : '0;

        a_r7_grant_eligible: assert property (@(posedge clk) disable iff (!rst_n)
            grant_vld[s] |-> (thr_active[pick_tid[s]] && !thr_imiss[pick_tid[s]]
                              && !thr_flush[pick_tid[s]]));
        a_r7_empty_zero: assert property (@(posedge clk) disable iff (!rst_n)
            !grant_vld[s] |-> (pick_tid[s] == '0 && grant_budget[s*BW +: BW] == '0));
        if (s > 0) begin : g_pair
            a_r2_packed: assert property (@(posedge clk) disable iff (!rst_n)
                grant_vld[s] |-> grant_vld[s-1]);
            a_r3_ranked: assert property (@(posedge clk) disable iff (!rst_n)
                grant_vld[s] |-> (key[pick_tid[s-1]] <= key[pick_tid[s]]));
            for (genvar r = 0; r < s; r++) begin : g_dist
                a_r7_distinct: assert property (@(posedge clk) disable iff (!rst_n)
                    grant_vld[s] |-> (pick_tid[s] != pick_tid[r]));
            end
        end
    end

    a_r2_slot_limit: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(grant_vld) <= int'(nslots));
    a_r8_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (|grant_vld) |=> (ptr == IW'($past(ptr) + 1'b1)));
    a_r8_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(|grant_vld) |=> $stable(ptr));
endmodule

// File: tb/fts_select_bench.sv
`timescale 1ns/1ps
module fts_select_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cfg_policy = '0, cfg_mode = '0;
    logic [7:0]  thr_active = '0, thr_imiss = '0, thr_flush = '0;
    logic [7:0]  occ_inc = '0, occ_dec = '0, br_inc = '0, br_dec = '0;
    logic [7:0]  dmiss_inc = '0, dmiss_dec = '0;
    logic [47:0] qpos_dist = '0;
    logic [3:0]  grant_vld;
    logic [11:0] grant_tid;
    logic [15:0] grant_budget;

    int n_tests = 0;
    int n_fail  = 0;

    always #2.5 clk = ~clk;

    fts_select u_fts_select (
        .clk(clk), .rst_n(rst_n), .cfg_policy(cfg_policy), .cfg_mode(cfg_mode),
        .thr_active(thr_active), .thr_imiss(thr_imiss), .thr_flush(thr_flush),
        .occ_inc(occ_inc), .occ_dec(occ_dec), .br_inc(br_inc), .br_dec(br_dec),
        .dmiss_inc(dmiss_inc), .dmiss_dec(dmiss_dec), .qpos_dist(qpos_dist),
        .grant_vld(grant_vld), .grant_tid(grant_tid), .grant_budget(grant_budget));

    // Vector: [27:26] policy, [25:24] mode, [23:16] active, [15:12] valid, [11:0] slot IDs.
    localparam int NV = 10;
    localparam logic [27:0] VEC [NV] = '{
        {2'd0, 2'd0, 8'hFF, 4'b0001, 3'd0, 3'd0, 3'd0, 3'd5},  // R3 R2
        {2'd0, 2'd2, 8'hFF, 4'b1111, 3'd1, 3'd7, 3'd3, 3'd5},  // R3 R2
        {2'd0, 2'd1, 8'hD7, 4'b0011, 3'd0, 3'd0, 3'd1, 3'd7},  // R3 R7
        {2'd1, 2'd2, 8'hFF, 4'b1111, 3'd6, 3'd0, 3'd4, 3'd2},  // R4
        {2'd1, 2'd3, 8'hFF, 4'b0011, 3'd0, 3'd0, 3'd4, 3'd2},  // R4 R2
        {2'd2, 2'd2, 8'hFF, 4'b1111, 3'd7, 3'd5, 3'd3, 3'd1},  // R5
        {2'd2, 2'd2, 8'h05, 4'b0011, 3'd0, 3'd0, 3'd0, 3'd2},  // R5 R7
        {2'd3, 2'd2, 8'hFF, 4'b1111, 3'd4, 3'd1, 3'd6, 3'd3},  // R6
        {2'd3, 2'd1, 8'h21, 4'b0011, 3'd0, 3'd0, 3'd5, 3'd0},  // R6
        {2'd0, 2'd2, 8'h00, 4'b0000, 3'd0, 3'd0, 3'd0, 3'd0}   // R7
    };

    function automatic logic [3:0] mode_budget(input logic [1:0] md);
        case (md)
            2'd0: return 4'd8;
            2'd1: return 4'd4;
            2'd2: return 4'd2;
            default: return 4'd8;
        endcase
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Checks all grant outputs against the expected valid bits, IDs and mode budget.
    task automatic chk_grant(input string req, input logic [3:0] ev, input logic [11:0] et,
                             input logic [1:0] md);
        logic [15:0] eb;
        eb = '0;
        for (int s = 0; s < 4; s++) eb[s*4 +: 4] = ev[s] ? mode_budget(md) : 4'd0;
        check({req, " valid"},  {12'd0, grant_vld}, {12'd0, ev});
        check({req, " id"},     {4'd0, grant_tid},  {4'd0, et});
        check({req, " budget"}, grant_budget, eb);
    endtask

    // Drives the config at a falling edge, checks one time unit later, then freezes the pointer.
    task automatic probe(input string req, input logic [1:0] pol, input logic [1:0] md,
                         input logic [7:0] act, input logic [3:0] ev, input logic [11:0] et);
        @(negedge clk);
        cfg_policy = pol; cfg_mode = md; thr_active = act;
        #1;
        chk_grant(req, ev, et, md);
        thr_active = '0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        thr_active = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : main
        int occ_v [8] = '{5, 3, 7, 1, 6, 0, 4, 2};
        int br_v  [8] = '{2, 6, 0, 4, 1, 7, 3, 5};
        int dm_v  [8] = '{7, 0, 6, 1, 5, 2, 4, 3};
        int dist_v[8] = '{10, 40, 20, 60, 30, 0, 50, 15};

        do_reset();
        // R1: no eligible thread after reset gives no grant.
        probe("R1 idle", 2'd0, 2'd2, 8'h00, 4'b0000, 12'd0);

        // R1 R8: equal keys, pointer 0, then 1, then wrap check.
        @(negedge clk);
        cfg_policy = 2'd0; cfg_mode = 2'd2; thr_active = 8'hFF;
        #1 chk_grant("R1 reset order", 4'b1111, {3'd3, 3'd2, 3'd1, 3'd0}, 2'd2);
        @(negedge clk);
        #1 chk_grant("R8 rotate", 4'b1111, {3'd4, 3'd3, 3'd2, 3'd1}, 2'd2);
        thr_active = 8'h81;
        #1 chk_grant("R8 wrap", 4'b0011, {3'd0, 3'd0, 3'd0, 3'd7}, 2'd2);
        thr_active = '0;

        // Preset distinct metrics with every thread ineligible.
        for (int t = 0; t < 8; t++) qpos_dist[t*6 +: 6] = 6'(dist_v[t]);
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            for (int t = 0; t < 8; t++) begin
                occ_inc[t]   = (k < occ_v[t]);
                br_inc[t]    = (k < br_v[t]);
                dmiss_inc[t] = (k < dm_v[t]);
            end
        end
        @(negedge clk);
        occ_inc = '0; br_inc = '0; dmiss_inc = '0;

        for (int i = 0; i < NV; i++) begin
            probe($sformatf("R2-R7 vec%0d", i), VEC[i][27:26], VEC[i][25:24],
                  VEC[i][23:16], VEC[i][15:12], VEC[i][11:0]);
        end

        // R9: saturation at both ends and net-zero updates.
        do_reset();
        for (int k = 0; k < 70; k++) begin
            @(negedge clk);
            occ_inc = {4'd0, 1'(k < 4), 1'(k < 3), 1'(k < 62), 1'b1};
        end
        @(negedge clk);
        occ_inc = '0;
        probe("R9 top saturate", 2'd0, 2'd1, 8'h03, 4'b0011, {3'd0, 3'd0, 3'd0, 3'd1});
        for (int k = 0; k < 66; k++) begin
            @(negedge clk);
            occ_dec = 8'h01;
        end
        @(negedge clk);
        occ_dec = '0;
        probe("R9 bottom saturate", 2'd0, 2'd1, 8'h05, 4'b0011, {3'd0, 3'd0, 3'd2, 3'd0});
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            occ_inc = 8'h04; occ_dec = 8'h04;
        end
        @(negedge clk);
        occ_inc = '0; occ_dec = '0;
        probe("R9 net zero", 2'd0, 2'd1, 8'h0C, 4'b0011, {3'd0, 3'd0, 3'd3, 3'd2});

        // R10 R7: flush exclusion in the same cycle and clearing at the edge.
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            br_inc    = {3'd0, 1'(k < 2), 1'b1, 3'd0};
            dmiss_inc = {3'd0, 1'(k < 1), 1'b1, 3'd0};
        end
        @(negedge clk);
        br_inc = '0; dmiss_inc = '0;
        probe("R4 before flush", 2'd1, 2'd1, 8'h18, 4'b0011, {3'd0, 3'd0, 3'd3, 3'd4});
        @(negedge clk);
        thr_flush = 8'h08; cfg_policy = 2'd1; cfg_mode = 2'd1; thr_active = 8'h18;
        #1 chk_grant("R7 flush excluded", 4'b0001, {3'd0, 3'd0, 3'd0, 3'd4}, 2'd1);
        thr_active = '0;
        @(negedge clk);
        thr_flush = '0;
        probe("R10 branch cleared", 2'd1, 2'd1, 8'h18, 4'b0011, {3'd0, 3'd0, 3'd4, 3'd3});
        probe("R10 miss cleared",   2'd2, 2'd1, 8'h18, 4'b0011, {3'd0, 3'd0, 3'd4, 3'd3});
        probe("R10 occ cleared",    2'd0, 2'd1, 8'h0C, 4'b0011, {3'd0, 3'd0, 3'd2, 3'd3});

        // R7: fetch-miss stall masks threads; empty slots report zero.
        @(negedge clk);
        thr_imiss = 8'hFE;
        probe("R7 imiss masked", 2'd0, 2'd2, 8'hFF, 4'b0001, 12'd0);
        thr_imiss = '0;

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule